// File: doc/BRIEF.md
# Maskable Sticky-Event Interrupt Controller

The block turns single-cycle event pulses into sticky status bits, gates each bit with its own enable, and drives one interrupt request pin. Eight per-reference change events (a reference turning valid or invalid), an operating-state change, a brief loss of the selected reference and a line-code error each own one status bit. Software reads status, mask and configuration through an 8-bit register port, and clears status bits by writing ones to them.

The request pin has a programmable active level. When no enabled status bit is pending, the pin either drives its inactive level or releases its output enable so that an external pull can hold the line. Event detection is done elsewhere; this block only records, masks and signals.

Top module: `irq_w1c_ctrl`

## Requirements
- R1: An event pulse sets its status bit at the next rising clock edge, whether or not the bit is masked.
- R2: A set status bit stays set after its event is gone, and writing 0 to it leaves it set.
- R3: Writing 1 to a status bit clears it at the write edge. Bits written with 0 in the same byte are unchanged.
- R4: When an event and a clear hit the same bit in the same cycle, the bit is set afterwards.
- R5: Mask bits reset to 0 (disabled). Writing 1 enables the source. A masked set bit does not assert the request, and it asserts the request as soon as it is unmasked.
- R6: The request is active exactly while at least one status bit is both set and enabled.
- R7: Config bit 0 selects polarity: 1 means the pin is 1 while active and 0 while inactive; 0 means the reverse.
- R8: Config bit 1 set means the output enable is 0 while the request is inactive. While active, or with bit 1 clear, the output enable is 1. The pin value always follows R7.
- R9: After reset, status, mask and config read 0, the pin is 1 and the output enable is 1.
- R10: Address map (8-bit data): status at 0 (bits 0-7 = reference events 0-7) and 1 (bit 0 state change, bit 1 brief loss, bit 2 line-code error), mask at 2 and 3 with the same bit layout, config at 4. Unused bits and unmapped addresses read 0.
- R11: A write never sets a status bit; only an event does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_chg_i | input | 8 | Per-reference valid/invalid change pulses |
| state_chg_i | input | 1 | Operating-state change pulse |
| ref_loss_i | input | 1 | Brief loss of selected reference pulse |
| code_err_i | input | 1 | Line-code error pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_pin_o | output | 1 | Request pin value |
| irq_oe_o | output | 1 | Request pin output enable |

## Verification
The bench hits a bit with an event and a clear in the same cycle; a design that let the clear win would lose the event and read 0. It sets a bit while masked and then unmasks it; a design that gated the set with the mask would never raise the request. It writes all ones to a clear status byte and writes zero to a set one, which catches a status register written as ordinary storage. It walks every combination of polarity and release mode with the request both idle and active, so a swapped level or an output enable tied high shows at the pin.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic release_idle;
    logic act_high;
  } irq_cfg_t;

  localparam int unsigned CFG_W = $bits(irq_cfg_t);

  function automatic int unsigned n_words(int unsigned bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_o[b] <= 1'b0;
      else if (set_i[b]) sts_o[b] <= 1'b1;  // event beats clear
      else if (clr_i[b]) sts_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_pkg::*;
#(
  parameter int unsigned N      = 11,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [N-1:0]      sts_i,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      msk_o,
  output irq_cfg_t          cfg_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned W        = n_words(N);
  localparam int unsigned PAD_W    = W * BYTE_W;
  localparam int unsigned STS_BASE = 0;
  localparam int unsigned MSK_BASE = W;
  localparam int unsigned CFG_ADDR = 2 * W;

  for (genvar b = 0; b < N; b++) begin : g_bit
    localparam int unsigned WRD = b / BYTE_W;
    localparam int unsigned POS = b % BYTE_W;
    logic hit_sts, hit_msk;
    assign hit_sts = wr_en_i && (addr_i == ADDR_W'(STS_BASE + WRD));
    assign hit_msk = wr_en_i && (addr_i == ADDR_W'(MSK_BASE + WRD));
    assign clr_o[b] = hit_sts && wdata_i[POS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      msk_o[b] <= 1'b0;
      else if (hit_msk) msk_o[b] <= wdata_i[POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_o <= '0;
    else if (wr_en_i && (addr_i == ADDR_W'(CFG_ADDR)))
      cfg_o <= irq_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  logic [PAD_W-1:0] sts_pad, msk_pad;
  always_comb begin
    sts_pad = '0;
    msk_pad = '0;
    sts_pad[N-1:0] = sts_i;
    msk_pad[N-1:0] = msk_o;
  end

  always_comb begin
    rdata_o = '0;
    for (int unsigned k = 0; k < W; k++) begin
      if (addr_i == ADDR_W'(STS_BASE + k)) rdata_o = sts_pad[k*BYTE_W +: BYTE_W];
      if (addr_i == ADDR_W'(MSK_BASE + k)) rdata_o = msk_pad[k*BYTE_W +: BYTE_W];
    end
    if (addr_i == ADDR_W'(CFG_ADDR)) rdata_o[CFG_W-1:0] = cfg_o;
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
  import irq_pkg::*;
#(
  parameter int unsigned N = 11
) (
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] msk_i,
  input  irq_cfg_t     cfg_i,
  output logic         pin_o,
  output logic         oe_o
);
  logic pending;
  assign pending = |(sts_i & msk_i);
  assign pin_o   = pending ~^ cfg_i.act_high;
  assign oe_o    = pending || !cfg_i.release_idle;
endmodule

// File: rtl/irq_w1c_ctrl.sv
module irq_w1c_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_REF = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REF-1:0] ref_chg_i,
  input  logic               state_chg_i,
  input  logic               ref_loss_i,
  input  logic               code_err_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  output logic [BYTE_W-1:0]  rdata_o,
  output logic               irq_pin_o,
  output logic               irq_oe_o
);
  localparam int unsigned NUM_EVT = NUM_REF + 3;

  logic [NUM_EVT-1:0] evt, clr, sts_q, msk_q;
  irq_cfg_t           cfg_q;

  assign evt = {code_err_i, ref_loss_i, state_chg_i, ref_chg_i};

  irq_sticky_bank #(.N(NUM_EVT)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt),
    .clr_i (clr),
    .sts_o (sts_q)
  );

  irq_reg_if #(.N(NUM_EVT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .sts_i  (sts_q),
    .clr_o  (clr),
    .msk_o  (msk_q),
    .cfg_o  (cfg_q),
    .rdata_o(rdata_o)
  );

  irq_pin_drv #(.N(NUM_EVT)) u_pin (
    .sts_i(sts_q),
    .msk_i(msk_q),
    .cfg_i(cfg_q),
    .pin_o(irq_pin_o),
    .oe_o (irq_oe_o)
  );
endmodule

// File: rtl/irq_w1c_ctrl_chk.sv
module irq_w1c_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned N      = 11,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      evt,
  input logic [N-1:0]      sts,
  input logic [N-1:0]      msk,
  input irq_cfg_t          cfg,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              irq_pin_o,
  input logic              irq_oe_o
);
  logic pending;
  assign pending = (sts & msk) != '0;

  // R1 and R4: every event lands, even under a clear
  assert_evt_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((sts & $past(evt)) == $past(evt)));

  assert_no_write_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts & ~$past(sts) & ~$past(evt)) == '0));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0 && (wdata_i & 8'h01) != '0 && !evt[0]) |=> !sts[0]);

  assert_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending |-> (irq_oe_o && irq_pin_o == cfg.act_high));

  assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending |-> (irq_pin_o == !cfg.act_high));

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending |-> (irq_oe_o == !cfg.release_idle));
endmodule

bind irq_w1c_ctrl irq_w1c_ctrl_chk #(.N(NUM_EVT), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt      (evt),
  .sts      (sts_q),
  .msk      (msk_q),
  .cfg      (cfg_q),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_pin_o(irq_pin_o),
  .irq_oe_o (irq_oe_o)
);

// File: tb/irq_w1c_ctrl_test.sv
module irq_w1c_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ref_chg = '0;
  logic       state_chg = 1'b0, ref_loss = 1'b0, code_err = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pin, oe;

  irq_w1c_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ref_chg_i(ref_chg), .state_chg_i(state_chg), .ref_loss_i(ref_loss), .code_err_i(code_err),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_pin_o(pin), .irq_oe_o(oe)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int         kind;  // 0 rdata, 1 pin, 2 oe
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  // monitor: compare queued expectations mid low phase
  initial forever begin
    @(negedge clk);
    #5;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? {7'b0, pin} : {7'b0, oe};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic chk(input logic [3:0] a, input logic [7:0] e_rd,
                     input logic e_pin, input logic e_oe, input string tag);
    addr = a;
    q.push_back('{0, e_rd, tag});
    q.push_back('{1, {7'b0, e_pin}, tag});
    q.push_back('{2, {7'b0, e_oe}, tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [10:0] e);
    {code_err, ref_loss, state_chg, ref_chg} = e;
    @(negedge clk);
    {code_err, ref_loss, state_chg, ref_chg} = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(4'd0, 8'h00, 1, 1, "R9");
    chk(4'd2, 8'h00, 1, 1, "R9");
    chk(4'd4, 8'h00, 1, 1, "R9");
    // R1 event sets bit while masked; R5 masked bit no request
    pulse(11'h008);
    chk(4'd0, 8'h08, 1, 1, "R1");
    chk(4'd0, 8'h08, 1, 1, "R5");
    // R2 sticky and write-0 no effect
    repeat (3) @(negedge clk);
    chk(4'd0, 8'h08, 1, 1, "R2");
    wr(4'd0, 8'h00);
    chk(4'd0, 8'h08, 1, 1, "R2");
    // R6 unmask -> request (active low default)
    wr(4'd2, 8'h08);
    chk(4'd2, 8'h08, 0, 1, "R6");
    // R3 clear -> request drops
    wr(4'd0, 8'h08);
    chk(4'd0, 8'h00, 1, 1, "R3");
    // R10 upper word layout: state change bit0, line-code bit2
    pulse(11'h500);
    chk(4'd1, 8'h05, 1, 1, "R10");
    wr(4'd1, 8'h01);
    chk(4'd1, 8'h04, 1, 1, "R3");
    wr(4'd1, 8'h04);
    chk(4'd1, 8'h00, 1, 1, "R3");
    // R11 writes never set status
    wr(4'd0, 8'hFF);
    chk(4'd0, 8'h00, 1, 1, "R11");
    // R4 event and clear same cycle
    ref_chg = 8'h04;
    wr(4'd0, 8'h04);
    ref_chg = '0;
    chk(4'd0, 8'h04, 1, 1, "R4");
    // R5 unmasking an already set bit asserts
    wr(4'd2, 8'h04);
    chk(4'd2, 8'h04, 0, 1, "R5");
    // R7 active high
    wr(4'd4, 8'h01);
    chk(4'd4, 8'h01, 1, 1, "R7");
    wr(4'd0, 8'h04);
    chk(4'd0, 8'h00, 0, 1, "R7");
    // R8 release while idle
    wr(4'd4, 8'h03);
    chk(4'd4, 8'h03, 0, 0, "R8");
    wr(4'd3, 8'h02);
    pulse(11'h200);
    chk(4'd1, 8'h02, 1, 1, "R8");
    chk(4'd3, 8'h02, 1, 1, "R10");
    wr(4'd4, 8'h02);
    chk(4'd4, 8'h02, 0, 1, "R7");
    wr(4'd1, 8'h02);
    chk(4'd1, 8'h00, 1, 0, "R8");
    // R10 unmapped address reads 0
    chk(4'd7, 8'h00, 1, 0, "R10");
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule